// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two predictors are built in. The per-branch predictor keeps a short outcome history for each branch slot, selected by PC bits. That history then picks a 3-bit saturating counter. The path predictor uses one shared history of recent outcomes to pick a 2-bit saturating counter. A third table of 2-bit counters, indexed by the shared history, learns which of the two predictors to trust for each history value.

The front end presents a PC on the predict port. In the same cycle, without a clock edge, it gets back the taken guess and a snapshot of the shared history. The shared history is advanced speculatively with each guess. When the branch resolves, the back end returns the PC, the actual outcome, the snapshot and a mispredict flag on the update port. This trains the tables. On a mispredict, the shared history is rebuilt from the snapshot.

Top module: `tourney_pred`

## Requirements
- R1: After reset the shared history reads zero. Every 3-bit counter holds 3 (weakly not-taken). Every 2-bit counter holds 1 (weakly not-taken). Every per-branch history is zero. So every PC is predicted not-taken.
- R2: The per-branch guess is the most significant bit of the 3-bit counter selected by the per-branch history. That history is selected by PC bits [LIDX+1:2].
- R3: The path guess is bit 1 of the 2-bit counter indexed by the shared history. The final guess is the path guess when bit 1 of the chooser counter at that index is 1, and the per-branch guess otherwise.
- R4: `pred_ghist` always shows the current shared history. This is the snapshot for the branch being predicted.
- R5: A predict request with no mispredict update in the same cycle shifts the shared history left by one. The guess enters at bit 0.
- R6: A mispredict update sets the shared history to the returned snapshot shifted left, with the actual outcome at bit 0. This takes priority over a same-cycle predict.
- R7: With neither a predict request nor a mispredict update, the shared history holds.
- R8: Each update moves the selected 3-bit and 2-bit counters one step toward the outcome. They saturate at 0 and at their maximum (7 or 3).
- R9: The chooser counter is trained only when the per-branch guess and the path guess differ at update time. It steps toward 3 if the path guess was right and toward 0 otherwise, saturating at both ends.
- R10: Each update shifts the branch's per-branch history left, with the outcome at bit 0. Both the per-branch and the path guesses used for training are recomputed from table contents at the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Predict request |
| pred_pc | input | PC_W | PC of branch to predict |
| pred_taken | output | 1 | Taken guess |
| pred_ghist | output | GHW | Shared-history snapshot |
| upd_valid | input | 1 | Resolved branch update |
| upd_pc | input | PC_W | PC of resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_ghist | input | GHW | Snapshot returned with the branch |
| upd_mispred | input | 1 | Guess was wrong |

## Verification
The assertions assume that `upd_mispred` is asserted only together with `upd_valid`. They also assume that the inputs stay low while reset is held. The stimulus meets both conditions because it builds every update from a prediction one cycle older. It raises the mispredict flag exactly when the recorded guess differs from the chosen outcome, and it idles all valids during reset. The returned snapshot is always the one the block produced, so the restore check matches a real pipeline.

// File: rtl/tourney_pred.sv
module tourney_pred #(
  parameter int PC_W = 32,
  parameter int LIDX = 10,
  parameter int LHW  = 10,
  parameter int GHW  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pred_valid,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic [GHW-1:0]  pred_ghist,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [GHW-1:0]  upd_ghist,
  input  logic            upd_mispred
);
  localparam int LN  = 1 << LIDX;
  localparam int LCN = 1 << LHW;
  localparam int GN  = 1 << GHW;

  logic [LHW-1:0] lht [LN];
  logic [2:0]     lct [LCN];
  logic [1:0]     gct [GN];
  logic [1:0]     cht [GN];
  logic [GHW-1:0] ghist;

  function automatic logic [2:0] step3(input logic [2:0] c, input logic up);
    if (up) return (c == 3'd7) ? c : c + 3'd1;
    else    return (c == 3'd0) ? c : c - 3'd1;
  endfunction

  function automatic logic [1:0] step2(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  wire [LIDX-1:0] p_li  = pred_pc[LIDX+1:2];
  wire [LHW-1:0]  p_lh  = lht[p_li];
  wire            p_loc = lct[p_lh][2];
  wire            p_glb = gct[ghist][1];
  wire            use_g = cht[ghist][1];

  assign pred_taken = use_g ? p_glb : p_loc;
  assign pred_ghist = ghist;

  wire [LIDX-1:0] u_li  = upd_pc[LIDX+1:2];
  wire [LHW-1:0]  u_lh  = lht[u_li];
  wire [2:0]      u_lc  = lct[u_lh];
  wire [1:0]      u_gc  = gct[upd_ghist];
  wire [1:0]      u_cc  = cht[upd_ghist];
  wire            u_loc = u_lc[2];
  wire            u_glb = u_gc[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LN; i++)  lht[i] <= '0;
      for (int i = 0; i < LCN; i++) lct[i] <= 3'd3;
      for (int i = 0; i < GN; i++) begin
        gct[i] <= 2'd1;
        cht[i] <= 2'd1;
      end
    end else if (upd_valid) begin
      lht[u_li]      <= {u_lh[LHW-2:0], upd_taken};
      lct[u_lh]      <= step3(u_lc, upd_taken);
      gct[upd_ghist] <= step2(u_gc, upd_taken);
      if (u_loc != u_glb)
        cht[upd_ghist] <= step2(u_cc, u_glb == upd_taken);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      ghist <= '0;
    else if (upd_valid && upd_mispred) ghist <= {upd_ghist[GHW-2:0], upd_taken};
    else if (pred_valid)             ghist <= {ghist[GHW-2:0], pred_taken};
  end
endmodule

module tourney_pred_chk #(
  parameter int PC_W = 32,
  parameter int GHW  = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pred_valid,
  input logic [PC_W-1:0] pred_pc,
  input logic            pred_taken,
  input logic [GHW-1:0]  pred_ghist,
  input logic            upd_valid,
  input logic            upd_taken,
  input logic [GHW-1:0]  upd_ghist,
  input logic            upd_mispred
);
  a_r5_spec_shift: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && !(upd_valid && upd_mispred)
    |=> pred_ghist == {$past(pred_ghist[GHW-2:0]), $past(pred_taken)});

  a_r6_restore: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_mispred
    |=> pred_ghist == {$past(upd_ghist[GHW-2:0]), $past(upd_taken)});

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid && !(upd_valid && upd_mispred) |=> $stable(pred_ghist));

  a_r3_no_update_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> (($stable(pred_pc) && $stable(pred_ghist)) -> $stable(pred_taken)));

  a_r2_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(pred_taken));
endmodule

bind tourney_pred tourney_pred_chk #(.PC_W(PC_W), .GHW(GHW)) u_chk (.*);

// File: tb/tb_tourney_pred.sv
module tb_tourney_pred;
  localparam int PC_W = 8, LIDX = 3, LHW = 4, GHW = 4;

  logic clk = 0, rst_n = 0;
  logic pred_valid = 0, upd_valid = 0, upd_taken = 0, upd_mispred = 0;
  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic [GHW-1:0] upd_ghist = '0;
  logic pred_taken;
  logic [GHW-1:0] pred_ghist;

  always #5 clk = ~clk;

  tourney_pred #(.PC_W(PC_W), .LIDX(LIDX), .LHW(LHW), .GHW(GHW)) dut (.*);

  int checks = 0, fails = 0;
  bit [LHW-1:0] mlht [1<<LIDX];
  bit [2:0] mlct [1<<LHW];
  bit [1:0] mgct [1<<GHW];
  bit [1:0] mcht [1<<GHW];
  bit [GHW-1:0] mgh;

  bit pv, pt, pend_v, pend_pred;
  bit [PC_W-1:0] pend_pc;
  bit [GHW-1:0] pend_gh;
  bit [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_pred(input bit [PC_W-1:0] pc);
    bit [LHW-1:0] lh = mlht[pc[LIDX+1:2]];
    return mcht[mgh][1] ? mgct[mgh][1] : mlct[lh][2];
  endfunction

  // one cycle: new prediction of pc with real outcome out, update of previous
  task automatic cyc(input string tag, input bit do_pred, input bit [PC_W-1:0] pc, input bit out);
    bit e, um, ut;
    bit [LIDX-1:0] li;
    bit [LHW-1:0] lh;
    bit lp, gp;
    @(negedge clk);
    um = pend_v && (pend_pred != pt);
    ut = pt;
    pred_valid = do_pred; pred_pc = pc;
    upd_valid = pend_v; upd_pc = pend_pc; upd_taken = ut;
    upd_ghist = pend_gh; upd_mispred = um;
    #2;
    e = exp_pred(pc);
    if (do_pred) chk({tag, " R2 R3 guess"}, int'(pred_taken), int'(e));
    chk("R4 snapshot", int'(pred_ghist), int'(mgh));
    // model update
    if (pend_v) begin
      li = pend_pc[LIDX+1:2]; lh = mlht[li];
      lp = mlct[lh][2]; gp = mgct[pend_gh][1];
      if (lp != gp) begin
        if (gp == ut) mcht[pend_gh] = (mcht[pend_gh] == 3) ? 2'd3 : mcht[pend_gh] + 1;
        else          mcht[pend_gh] = (mcht[pend_gh] == 0) ? 2'd0 : mcht[pend_gh] - 1;
      end
      if (ut) begin
        mlct[lh] = (mlct[lh] == 7) ? 3'd7 : mlct[lh] + 1;
        mgct[pend_gh] = (mgct[pend_gh] == 3) ? 2'd3 : mgct[pend_gh] + 1;
      end else begin
        mlct[lh] = (mlct[lh] == 0) ? 3'd0 : mlct[lh] - 1;
        mgct[pend_gh] = (mgct[pend_gh] == 0) ? 2'd0 : mgct[pend_gh] - 1;
      end
      mlht[li] = {lh[LHW-2:0], ut};
    end
    pend_v = do_pred; pend_pc = pc; pend_pred = e; pend_gh = mgh; pt = out;
    if (um) mgh = {upd_ghist[GHW-2:0], ut};
    else if (do_pred) mgh = {mgh[GHW-2:0], e};
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<LIDX); i++) mlht[i] = '0;
    for (int i = 0; i < (1<<LHW); i++) mlct[i] = 3'd3;
    for (int i = 0; i < (1<<GHW); i++) begin mgct[i] = 2'd1; mcht[i] = 2'd1; end
    mgh = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #2;
    // R1: every PC slot predicts not-taken, history zero
    for (int p = 0; p < (1<<LIDX); p++) begin
      pred_pc = PC_W'(p << 2);
      #1 chk("R1 reset guess", int'(pred_taken), 0);
    end
    chk("R1 reset history", int'(pred_ghist), 0);
    // R8: saturate a taken branch, then one not-taken leaves it taken
    for (int k = 0; k < 40; k++) cyc("R8 saturate", 1, 8'h10, 1);
    cyc("R8 single flip", 1, 8'h10, 0);
    for (int k = 0; k < 4; k++) cyc("R8 recover", 1, 8'h10, 1);
    // R7: idle cycles hold history
    for (int k = 0; k < 6; k++) cyc("R7 idle", 0, 8'h00, 0);
    // R10: alternating branch learned via per-branch history
    for (int k = 0; k < 200; k++) cyc("R10 alternate", 1, 8'h24, k[0]);
    // R9: loop pattern interleaved with correlated branch
    for (int k = 0; k < 300; k++) begin
      if (k % 2 == 0) cyc("R9 loop", 1, 8'h08, (k % 8) != 6);
      else            cyc("R9 corr", 1, 8'h0C, pt);
    end
    // R5 R6: pseudo-random outcomes over every PC slot, with idle gaps
    for (int k = 0; k < 2000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pv = lfsr[3:0] != 0;
      cyc("R5 R6 random", pv, {lfsr[7:4], 2'b00}, lfsr[8] ^ lfsr[2]);
    end
    // exhaustive fixed patterns per slot
    for (int s = 0; s < (1<<LIDX); s++)
      for (int pat = 0; pat < 4; pat++)
        for (int k = 0; k < 24; k++)
          cyc("R2 R3 sweep", 1, PC_W'(s << 2), pat == 0 ? 1'b1 : pat == 1 ? 1'b0 :
              pat == 2 ? k[0] : (k % 3 != 0));
    cyc("R6 drain", 0, 8'h00, 0);
    cyc("R7 drain", 0, 8'h00, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule